// File: doc/BRIEF.md
# Dual-Channel Disk Card Bus Decoder

This block sits on the host side of an expansion card that carries two disk-drive channels. It takes a synchronous byte-wide host bus and splits the card's address space into targets. Each channel has a taskfile window and an alternate status/control register. Each channel also has an interrupt-enable port and an interrupt-status port. Channel 1's page holds a read-only card-type ident, and address zero holds a card control register. Accesses to a taskfile or alternate register go straight to the drive side as a chip select, a register index and read/write strobes. Read data returns to the host one cycle after the read strobe.

Each channel's drive interrupt is gated by its own enable, and the gated requests are ORed into one host interrupt. The enables are driven by the type of access rather than by data. A write to a channel's interrupt port arms that channel and disarms the other one. A read of the same port disarms that channel. The control register steers the card's single DMA request/acknowledge pair to one channel and drives an enable for the alternate register region.

Top module: `twinport_irq_decoder`

## Requirements
- R1: An address of 0x2000 + (n << 6) (channel 1) or 0x3000 + (n << 6) (channel 2), with n from 0 to 7, asserts devCs bit 0 or bit 1 in the same cycle, with devReg = n and devAlt = 0. devWr and devRd follow busWe and busRd in that cycle, and devWdata equals busWdata. A read returns drvRdata, sampled at the strobe edge, on busRdata one cycle later.
- R2: Address 0x2380 (channel 1) or 0x3380 (channel 2) selects that channel with devAlt = 1 and devReg = 0. A read there returns drvRdata one cycle later.
- R3: A write of any value to 0x2200 (channel 1) or 0x3200 (channel 2) sets that channel's interrupt enable and clears the other channel's, from the next cycle. At most one enable is ever set.
- R4: A read of 0x2200 or 0x3200 clears only that channel's enable and returns 0x00.
- R5: A read of 0x2290 (channel 1) or 0x3290 (channel 2) returns the raw drvIrq bit of that channel in bit 0, with bits 7:1 zero. The read does not change either enable.
- R6: hostIrq is high, in the same cycle, exactly when some channel has both drvIrq and its enable set.
- R7: Bit 0 of the bytes at 0x2280, 0x2284, 0x2288 and 0x228C gives card-type bits 0 to 3 of the value 3, so those reads return 1, 1, 0 and 0. Bits 7:1 are zero. Address 0x3280 is unmapped.
- R8: The control register at 0x0000 is read/write and resets to 0. Bit 5 drives altRegionEn and bit 0 drives dmaSel. A write of 0 restores the reset state.
- R9: hostDmaReq equals drvDmaReq[dmaSel]. drvDmaAck[dmaSel] follows hostDmaAck, and the other acknowledge bit is 0.
- R10: A read of any other address returns 0x00, and a write there changes no state. busRdata is 0x00 in every cycle that does not follow a read strobe.
- R11: After reset both enables are 0, the control register is 0 and busRdata is 0x00.
- R12: When busWe and busRd are high in the same cycle, the write takes effect, the read is ignored and busRdata is 0x00 the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 14 | Host byte address |
| busWe | input | 1 | Host write strobe |
| busRd | input | 1 | Host read strobe |
| busWdata | input | 8 | Host write data |
| busRdata | output | 8 | Host read data, valid the cycle after busRd |
| drvIrq | input | 2 | Raw drive interrupt per channel |
| drvRdata | input | 8 | Drive-side read data for taskfile/alternate reads |
| devCs | output | 2 | Per-channel drive register select |
| devAlt | output | 1 | Alternate status/control register selected |
| devReg | output | 3 | Taskfile register index |
| devWr | output | 1 | Drive register write strobe |
| devRd | output | 1 | Drive register read strobe |
| devWdata | output | 8 | Drive-side write data |
| drvDmaReq | input | 2 | Per-channel DMA request |
| hostDmaAck | input | 1 | Host DMA acknowledge |
| hostDmaReq | output | 1 | Routed DMA request to host |
| drvDmaAck | output | 2 | Routed DMA acknowledge per channel |
| dmaSel | output | 1 | Channel that owns the DMA path |
| altRegionEn | output | 1 | Alternate register region enabled |
| hostIrq | output | 1 | Combined gated interrupt |

## Verification
The bench reads every address of the 14-bit space and compares each result with a value worked out from the address map. A decoder with a sloppy mask would return data at aliases, or miss one of the 64-byte-spaced taskfile registers. It applies every ordered pair of interrupt-port and status-port accesses from a clean state and observes the enables through hostIrq. This exposes an enable write that fails to disarm the other channel, a status read that has a side effect, or a port read that clears the wrong channel. It also drives simultaneous write and read strobes, and unmapped writes whose effects could only appear in the control register or the enables.

// File: rtl/twinport_pkg.sv
package twinport_pkg;
  localparam int N_CH       = 2;
  localparam int TF_REGS    = 8;
  localparam int REG_IDX_W  = $clog2(TF_REGS);
  localparam int IRQ_OFF    = 'h200;
  localparam int ID_OFF     = 'h280;
  localparam int STAT_OFF   = 'h290;
  localparam int ALT_OFF    = 'h380;
  localparam int CTL_DMA_BIT = 0;
  localparam int CTL_ALT_BIT = 5;

  typedef struct packed {
    logic                 wrEn;
    logic                 rdEn;
    logic                 ch;
    logic                 tfHit;
    logic                 altHit;
    logic [REG_IDX_W-1:0] regIdx;
    logic [N_CH-1:0]      irqWr;
    logic [N_CH-1:0]      irqRd;
    logic [N_CH-1:0]      statRd;
    logic                 idRd;
    logic [1:0]           idIdx;
    logic                 ctlWr;
    logic                 ctlRd;
  } decStrobe_t;
endpackage

// File: rtl/twinport_ctrl.sv
module twinport_ctrl
  import twinport_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int REG_SHIFT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRd,
  output decStrobe_t        dec
);
  localparam int OFF_W  = ADDR_W - 2;
  localparam int IDX_HI = REG_SHIFT + REG_IDX_W;

  logic             inPage;
  logic             chBit;
  logic [OFF_W-1:0] off;
  logic             rdOnly;
  logic             tfShape;
  logic             idShape;
  logic             ctlAddr;
  logic [N_CH-1:0]  irqWrV;
  logic [N_CH-1:0]  irqRdV;
  logic [N_CH-1:0]  statRdV;

  assign inPage  = busAddr[ADDR_W-1];
  assign chBit   = busAddr[ADDR_W-2];
  assign off     = busAddr[OFF_W-1:0];
  assign rdOnly  = busRd & ~busWe;
  assign tfShape = (off[OFF_W-1:IDX_HI] == '0) && (off[REG_SHIFT-1:0] == '0);
  assign idShape = (off[OFF_W-1:4] == (OFF_W-4)'(ID_OFF >> 4)) && (off[1:0] == 2'b00);
  assign ctlAddr = (busAddr == '0);

  for (genvar c = 0; c < N_CH; c++) begin : g_chDec
    logic hitPage;
    assign hitPage    = inPage && (chBit == 1'(c));
    assign irqWrV[c]  = hitPage && (off == OFF_W'(IRQ_OFF)) && busWe;
    assign irqRdV[c]  = hitPage && (off == OFF_W'(IRQ_OFF)) && rdOnly;
    assign statRdV[c] = hitPage && (off == OFF_W'(STAT_OFF)) && rdOnly;
  end

  always_comb begin
    dec        = '0;
    dec.wrEn   = busWe;
    dec.rdEn   = rdOnly;
    dec.ch     = chBit;
    dec.tfHit  = inPage && tfShape;
    dec.altHit = inPage && (off == OFF_W'(ALT_OFF));
    if (inPage && tfShape) dec.regIdx = off[IDX_HI-1:REG_SHIFT];
    dec.irqWr  = irqWrV;
    dec.irqRd  = irqRdV;
    dec.statRd = statRdV;
    dec.idRd   = inPage && !chBit && idShape && rdOnly;
    dec.idIdx  = off[3:2];
    dec.ctlWr  = ctlAddr && busWe;
    dec.ctlRd  = ctlAddr && rdOnly;
  end

  // R10: one address never reaches two targets
  p_one_target_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({dec.tfHit, dec.altHit, dec.ctlWr | dec.ctlRd, |dec.irqWr,
              |dec.irqRd, |dec.statRd, dec.idRd}));

  // R12: a write strobe suppresses every read-side target
  p_wr_masks_rd_r12: assert property (@(posedge clk) disable iff (!rstN)
    busWe |-> (dec.irqRd == '0 && dec.statRd == '0 && !dec.idRd && !dec.ctlRd));
endmodule

// File: rtl/twinport_datapath.sv
module twinport_datapath
  import twinport_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CARD_TYPE = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  decStrobe_t           dec,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [N_CH-1:0]      drvIrq,
  input  logic [DATA_W-1:0]    drvRdata,
  output logic [N_CH-1:0]      devCs,
  output logic                 devAlt,
  output logic [REG_IDX_W-1:0] devReg,
  output logic                 devWr,
  output logic                 devRd,
  output logic [DATA_W-1:0]    devWdata,
  input  logic [N_CH-1:0]      drvDmaReq,
  input  logic                 hostDmaAck,
  output logic                 hostDmaReq,
  output logic [N_CH-1:0]      drvDmaAck,
  output logic                 dmaSel,
  output logic                 altRegionEn,
  output logic                 hostIrq
);
  logic [N_CH-1:0]   irqEn;
  logic [DATA_W-1:0] ctlReg;
  logic [DATA_W-1:0] rdNext;
  logic              devHit;

  // interrupt enables: write arms own channel and disarms others; read disarms own
  for (genvar c = 0; c < N_CH; c++) begin : g_en
    always_ff @(posedge clk) begin
      if (!rstN)                irqEn[c] <= 1'b0;
      else if (dec.irqWr[c])    irqEn[c] <= 1'b1;
      else if (|dec.irqWr)      irqEn[c] <= 1'b0;
      else if (dec.irqRd[c])    irqEn[c] <= 1'b0;
    end

    // R3: write arms this channel
    p_wr_sets_r3: assert property (@(posedge clk) disable iff (!rstN)
      dec.irqWr[c] |=> irqEn[c]);
    // R3: write disarms the other channel
    p_wr_clears_other_r3: assert property (@(posedge clk) disable iff (!rstN)
      dec.irqWr[c] |=> !irqEn[N_CH-1-c]);
    // R4: read disarms this channel
    p_rd_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
      dec.irqRd[c] |=> !irqEn[c]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          ctlReg <= '0;
    else if (dec.ctlWr) ctlReg <= busWdata;
  end

  assign dmaSel      = ctlReg[CTL_DMA_BIT];
  assign altRegionEn = ctlReg[CTL_ALT_BIT];
  assign hostDmaReq  = drvDmaReq[dmaSel];

  for (genvar c = 0; c < N_CH; c++) begin : g_dma
    assign drvDmaAck[c] = hostDmaAck && (dmaSel == 1'(c));
    assign devCs[c]     = devHit && (dec.ch == 1'(c));
  end

  assign devHit   = dec.tfHit | dec.altHit;
  assign devAlt   = dec.altHit;
  assign devReg   = dec.regIdx;
  assign devWr    = devHit & dec.wrEn;
  assign devRd    = devHit & dec.rdEn;
  assign devWdata = busWdata;
  assign hostIrq  = |(drvIrq & irqEn);

  always_comb begin
    rdNext = '0;
    if (devHit)
      rdNext = drvRdata;
    else if (dec.statRd[0])
      rdNext = DATA_W'(drvIrq[0]);
    else if (dec.statRd[1])
      rdNext = DATA_W'(drvIrq[1]);
    else if (dec.idRd)
      rdNext = DATA_W'((CARD_TYPE >> dec.idIdx) & 1);
    else if (dec.ctlRd)
      rdNext = ctlReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          busRdata <= '0;
    else if (dec.rdEn)  busRdata <= rdNext;
    else                busRdata <= '0;
  end

  // R3: exclusive enables
  p_one_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqEn) <= 1);
  // R5: status reads leave enables alone
  p_stat_keeps_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|dec.statRd) |=> $stable(irqEn));
  // R6: a host interrupt needs an armed channel
  p_irq_needs_en_r6: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> (|irqEn));
  // R9: at most one channel sees the acknowledge
  p_ack_route_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(drvDmaAck));
  // R10: no read strobe, no data
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    !$past(dec.rdEn) |-> (busRdata == '0));
endmodule

// File: rtl/twinport_irq_decoder.sv
module twinport_irq_decoder
  import twinport_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int DATA_W    = 8,
  parameter int REG_SHIFT = 6,
  parameter int CARD_TYPE = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic                 busRd,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  input  logic [N_CH-1:0]      drvIrq,
  input  logic [DATA_W-1:0]    drvRdata,
  output logic [N_CH-1:0]      devCs,
  output logic                 devAlt,
  output logic [REG_IDX_W-1:0] devReg,
  output logic                 devWr,
  output logic                 devRd,
  output logic [DATA_W-1:0]    devWdata,
  input  logic [N_CH-1:0]      drvDmaReq,
  input  logic                 hostDmaAck,
  output logic                 hostDmaReq,
  output logic [N_CH-1:0]      drvDmaAck,
  output logic                 dmaSel,
  output logic                 altRegionEn,
  output logic                 hostIrq
);
  decStrobe_t dec;

  twinport_ctrl #(
    .ADDR_W   (ADDR_W),
    .REG_SHIFT(REG_SHIFT)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .busAddr(busAddr),
    .busWe  (busWe),
    .busRd  (busRd),
    .dec    (dec)
  );

  twinport_datapath #(
    .DATA_W   (DATA_W),
    .CARD_TYPE(CARD_TYPE)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dec        (dec),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .drvIrq     (drvIrq),
    .drvRdata   (drvRdata),
    .devCs      (devCs),
    .devAlt     (devAlt),
    .devReg     (devReg),
    .devWr      (devWr),
    .devRd      (devRd),
    .devWdata   (devWdata),
    .drvDmaReq  (drvDmaReq),
    .hostDmaAck (hostDmaAck),
    .hostDmaReq (hostDmaReq),
    .drvDmaAck  (drvDmaAck),
    .dmaSel     (dmaSel),
    .altRegionEn(altRegionEn),
    .hostIrq    (hostIrq)
  );

  // R12: a write cycle never produces read data
  p_wr_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> (busRdata == '0));
  // R1: drive strobes only with a chip select
  p_strobe_cs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (devWr || devRd) |-> $onehot(devCs));
endmodule

// File: tb/twinport_irq_decoder_bench.sv
module twinport_irq_decoder_bench;
  localparam int ADDR_W = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWe = 1'b0;
  logic              busRd = 1'b0;
  logic [7:0]        busWdata = '0;
  logic [7:0]        busRdata;
  logic [1:0]        drvIrq = '0;
  logic [7:0]        drvRdata = '0;
  logic [1:0]        devCs;
  logic              devAlt;
  logic [2:0]        devReg;
  logic              devWr;
  logic              devRd;
  logic [7:0]        devWdata;
  logic [1:0]        drvDmaReq = '0;
  logic              hostDmaAck = 1'b0;
  logic              hostDmaReq;
  logic [1:0]        drvDmaAck;
  logic              dmaSel;
  logic              altRegionEn;
  logic              hostIrq;

  int total = 0;
  int bad = 0;

  // values captured in the strobe cycle
  logic [1:0] seenCs;
  logic       seenAlt;
  logic [2:0] seenReg;
  logic       seenWr;
  logic       seenRd;
  logic [7:0] seenWdata;

  always #5 clk = ~clk;

  twinport_irq_decoder u_twinport_irq_decoder (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .drvIrq(drvIrq), .drvRdata(drvRdata),
    .devCs(devCs), .devAlt(devAlt), .devReg(devReg), .devWr(devWr), .devRd(devRd),
    .devWdata(devWdata), .drvDmaReq(drvDmaReq), .hostDmaAck(hostDmaAck),
    .hostDmaReq(hostDmaReq), .drvDmaAck(drvDmaAck), .dmaSel(dmaSel),
    .altRegionEn(altRegionEn), .hostIrq(hostIrq)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic capture();
    seenCs = devCs; seenAlt = devAlt; seenReg = devReg;
    seenWr = devWr; seenRd = devRd; seenWdata = devWdata;
  endtask

  task automatic doWrite(input int a, input logic [7:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a); busWdata = d; busWe = 1'b1;
    #1 capture();
    @(negedge clk);
    busWe = 1'b0; busAddr = '0;
  endtask

  task automatic doRead(input int a, output logic [7:0] d);
    @(negedge clk);
    busAddr = ADDR_W'(a); busRd = 1'b1;
    #1 capture();
    @(negedge clk);
    busRd = 1'b0; busAddr = '0;
    d = busRdata;
  endtask

  task automatic probeEn(output logic [1:0] e);
    logic [1:0] keep;
    keep = drvIrq;
    drvIrq = 2'b01; #1 e[0] = hostIrq;
    drvIrq = 2'b10; #1 e[1] = hostIrq;
    drvIrq = keep;  #1;
  endtask

  function automatic logic [7:0] expRd(int a, logic [7:0] ctl, logic [1:0] irq, logic [7:0] drv);
    int ch;
    int off;
    if (a == 0) return ctl;
    if (a < 'h2000) return 8'h00;
    ch  = (a >> 12) & 1;
    off = a & 'hFFF;
    if ((off >> 9) == 0 && (off % 64) == 0) return drv;
    if (off == 'h380) return drv;
    if (off == 'h290) return {7'b0, irq[ch]};
    if (ch == 0 && off >= 'h280 && off <= 'h28C && (off % 4) == 0)
      return 8'((3 >> ((off - 'h280) / 4)) & 1);
    return 8'h00;
  endfunction

  function automatic logic [1:0] expCs(int a);
    int off;
    if (a < 'h2000) return 2'b00;
    off = a & 'hFFF;
    if (((off >> 9) == 0 && (off % 64) == 0) || off == 'h380)
      return 2'b01 << ((a >> 12) & 1);
    return 2'b00;
  endfunction

  initial begin
    #1_500_000;
    total++; bad++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [1:0] e;
    logic [1:0] m;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11: reset state
    drvIrq = 2'b11;
    #1 check(hostIrq == 1'b0, "R11 hostIrq after reset", hostIrq, 0);
    check(busRdata == 8'h00, "R11 busRdata after reset", busRdata, 0);
    check({altRegionEn, dmaSel} == 2'b00, "R11 control after reset", {altRegionEn, dmaSel}, 0);
    drvIrq = 2'b00;

    // R1: every taskfile register of both channels
    for (int ch = 0; ch < 2; ch++) begin
      for (int n = 0; n < 8; n++) begin
        int a;
        a = 'h2000 + ch * 'h1000 + (n << 6);
        drvRdata = 8'(8'h40 + ch * 16 + n);
        doRead(a, d);
        check(seenCs == (2'b01 << ch) && seenReg == 3'(n) && !seenAlt && seenRd && !seenWr,
              "R1 taskfile read select", {seenCs, seenReg, seenAlt, seenRd}, {2'b01 << ch, 3'(n), 1'b0, 1'b1});
        check(d == drvRdata, "R1 taskfile read data", d, drvRdata);
        doWrite(a, 8'(8'h90 + n));
        check(seenCs == (2'b01 << ch) && seenReg == 3'(n) && seenWr && !seenRd
              && seenWdata == 8'(8'h90 + n),
              "R1 taskfile write select", {seenCs, seenReg, seenWr, seenWdata}, {2'b01 << ch, 3'(n), 1'b1, 8'(8'h90 + n)});
      end
      // R2: alternate register
      drvRdata = 8'(8'hC0 + ch);
      doRead('h2380 + ch * 'h1000, d);
      check(seenCs == (2'b01 << ch) && seenAlt && seenReg == 3'd0,
            "R2 alternate select", {seenCs, seenAlt, seenReg}, {2'b01 << ch, 1'b1, 3'd0});
      check(d == drvRdata, "R2 alternate read data", d, drvRdata);
    end

    // R7: card type ident
    for (int k = 0; k < 4; k++) begin
      doRead('h2280 + 4 * k, d);
      check(d == 8'((3 >> k) & 1), "R7 ident bit", d, (3 >> k) & 1);
    end
    doRead('h3280, d);
    check(d == 8'h00, "R7 ident absent on channel 2 page", d, 0);

    // R3 R4 R5: every ordered pair of port accesses from a clean state
    for (int op1 = 0; op1 < 6; op1++) begin
      for (int op2 = 0; op2 < 6; op2++) begin
        logic [1:0] model;
        doRead('h2200, d);
        doRead('h3200, d);
        model = 2'b00;
        drvIrq = 2'b10;
        for (int s = 0; s < 2; s++) begin
          int op;
          int ch;
          int base;
          op = (s == 0) ? op1 : op2;
          ch = op % 2;
          base = 'h2000 + ch * 'h1000;
          if (op < 2) begin
            doWrite(base + 'h200, 8'h00);
            model[ch] = 1'b1; model[1 - ch] = 1'b0;
          end else if (op < 4) begin
            doRead(base + 'h200, d);
            model[ch] = 1'b0;
            check(d == 8'h00, "R4 interrupt port read data", d, 0);
          end else begin
            doRead(base + 'h290, d);
            check(d == {7'b0, drvIrq[ch]}, "R5 status read data", d, drvIrq[ch]);
          end
        end
        probeEn(e);
        check(e == model, "R3 R4 R5 enables after access pair", e, model);
      end
    end

    // R6: combined interrupt over enable states and drive inputs, R5 raw status
    for (int st = 0; st < 3; st++) begin
      doRead('h2200, d);
      doRead('h3200, d);
      if (st == 1) doWrite('h2200, 8'hFF);
      if (st == 2) doWrite('h3200, 8'h5A);
      m = (st == 0) ? 2'b00 : (st == 1) ? 2'b01 : 2'b10;
      for (int v = 0; v < 4; v++) begin
        drvIrq = 2'(v);
        #1 check(hostIrq == |(2'(v) & m), "R6 combined interrupt", hostIrq, |(2'(v) & m));
        doRead('h3290, d);
        check(d == {7'b0, drvIrq[1]}, "R5 raw status channel 2", d, drvIrq[1]);
      end
      probeEn(e);
      check(e == m, "R5 status reads keep enables", e, m);
    end
    drvIrq = 2'b00;
    doRead('h2200, d);
    doRead('h3200, d);

    // R8 R9: control register and DMA routing
    doWrite('h0000, 8'h21);
    #1 check(altRegionEn && dmaSel, "R8 control bits drive outputs", {altRegionEn, dmaSel}, 3);
    doRead('h0000, d);
    check(d == 8'h21, "R8 control readback", d, 8'h21);
    for (int sel = 1; sel >= 0; sel--) begin
      if (sel == 0) doWrite('h0000, 8'h20);
      for (int v = 0; v < 8; v++) begin
        drvDmaReq = 2'(v & 3);
        hostDmaAck = v[2];
        #1;
        check(hostDmaReq == drvDmaReq[sel], "R9 request routing", hostDmaReq, drvDmaReq[sel]);
        check(drvDmaAck == (v[2] ? (2'b01 << sel) : 2'b00), "R9 acknowledge routing",
              drvDmaAck, v[2] ? (2'b01 << sel) : 0);
      end
    end
    drvDmaReq = '0; hostDmaAck = 1'b0;

    // R10: full address sweep of reads
    doWrite('h0000, 8'h21);
    drvIrq = 2'b01;
    drvRdata = 8'hA5;
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      doRead(a, d);
      check(d == expRd(a, 8'h21, 2'b01, 8'hA5) && seenCs == expCs(a),
            "R10 address sweep", {seenCs, d}, {expCs(a), expRd(a, 8'h21, 2'b01, 8'hA5)});
    end
    @(negedge clk);
    check(busRdata == 8'h00, "R10 idle cycle data", busRdata, 0);

    // R8: write 0 restores reset state
    doWrite('h0000, 8'h00);
    #1 check({altRegionEn, dmaSel} == 2'b00, "R8 control cleared", {altRegionEn, dmaSel}, 0);

    // R10: unmapped writes change nothing
    doWrite('h0004, 8'hFF);
    doWrite('h2201, 8'hFF);
    doWrite('h1200, 8'hFF);
    doWrite('h3280, 8'hFF);
    doWrite('h2290, 8'hFF);
    doRead('h0000, d);
    check(d == 8'h00, "R10 control unaffected by unmapped writes", d, 0);
    probeEn(e);
    check(e == 2'b00, "R10 enables unaffected by unmapped writes", e, 0);

    // R12: write and read together
    @(negedge clk);
    busAddr = '0; busWdata = 8'h20; busWe = 1'b1; busRd = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busRd = 1'b0;
    check(busRdata == 8'h00, "R12 read ignored during write", busRdata, 0);
    check(altRegionEn == 1'b1, "R12 write applied", altRegionEn, 1);
    @(negedge clk);
    busAddr = ADDR_W'('h3200); busWe = 1'b1; busRd = 1'b1;
    @(negedge clk);
    busWe = 1'b0; busRd = 1'b0; busAddr = '0;
    probeEn(e);
    check(e == 2'b10, "R12 interrupt port write wins", e, 2'b10);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule